// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a clocked host request port and an external asynchronous static RAM with a 32-bit data bus that is split into four byte lanes. The host offers one request at a time: a read or a write, a word address, write data and a per-byte enable mask. The controller turns each request into a timed sequence of pin activity: a shared active-low chip select, a shared active-low output enable, one active-low write strobe per byte lane and a bidirectional data bus.

All pin timing is set by nanosecond parameters: clock period, read access time, write pulse width, data setup before the end of the write and minimum write cycle. The block turns each one into a whole number of clock cycles, rounding up. A write pulses only the strobes of the enabled lanes, so the bytes of the other lanes stay as they were. The data bus is driven only during the write phases. It is always released for at least one idle cycle before output enable is asserted for a read. Each finished access is reported with a one-cycle response pulse, and for a read that pulse carries the word captured from the bus.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, sram_ce_n, sram_oe_n and every bit of sram_we_n are high, req_ready is 1 and rsp_valid is 0. Asserting reset in the middle of an access returns the pins to this state at once.
- R2: Whenever sram_ce_n is high, sram_oe_n and all four sram_we_n bits are high too (standby).
- R3: A read holds sram_ce_n and sram_oe_n low, with all write strobes high, for exactly RD_CYC = ceil(RD_ACC_NS / CLK_NS) cycles (2 by default). rsp_valid pulses RD_CYC clock edges after the accepting edge, and rsp_rdata then holds the bus word sampled in the last read cycle.
- R4: A write drives sram_we_n[i] low only for lanes with req_be[i] = 1 (bit i covers data bits 8i+7..8i). The strobe lasts WP_CYC = ceil(max(WR_PULSE_NS, WR_DSETUP_NS) / CLK_NS) cycles (1 by default), and sram_oe_n stays high throughout.
- R5: During the write strobe the controller drives the full request word on sram_dq. Lanes with enable 0 keep their earlier content, which a later read shows.
- R6: A write keeps sram_ce_n low for max(WP_CYC + 1, ceil(WR_CYCLE_NS / CLK_NS)) cycles (2 by default). The strobe phase is followed by at least one hold cycle with all strobes high and data still driven. rsp_valid pulses that many clock edges after the accepting edge.
- R7: Between the last write strobe cycle and the first cycle with sram_oe_n low, there is at least one cycle with sram_ce_n high, during which the controller does not drive sram_dq.
- R8: req_ready is 1 only while no access is in progress. A request is taken on a clock edge where req_valid and req_ready are both 1.
- R9: A write with req_be = 0 runs the full write timing of R6 but lowers no write strobe, and the memory is unchanged.
- R10: sram_addr holds the accepted request address, unchanged, for every cycle in which sram_ce_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte-lane enables for a write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid after a read |
| sram_addr | output | 17 | Memory address pins |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 4 | Per-lane write strobes, active low |
| sram_dq | inout | 32 | Bidirectional data bus |

## Verification
With a 20 ns clock, a read response arrives 2 edges after the accepting edge and a write response 2 edges after it. The first strobe or output-enable cycle begins on the edge right after acceptance. After setting a request, the bench samples every port at the falling edge of each following cycle, until the response pulse. From these samples it counts chip-select, output-enable and strobe cycles and the response latency in edges. Sampling mid-cycle means each count lands on the cycle that the state register sets, with no race at the edge. A behavioural memory in the bench stores bytes from the strobed lanes and returns words on reads. It starts from zero, so each expected read value follows from the table's write history.

// File: rtl/sram_lane_ctrl_pkg.sv
package sram_lane_ctrl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_STRB  = 2'd2,
      ST_HOLD  = 2'd3
   } acc_state_t;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // R6: the phase counter only steps down by one or reloads
   a_r6_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!zero && !load) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sram_lane_strobes.sv
module sram_lane_strobes
   import sram_lane_ctrl_pkg::*;
#(
   parameter int LANES = 4
) (
   input  acc_state_t       state,
   input  logic [LANES-1:0] be_q,
   output logic [LANES-1:0] we_n,
   output logic             drive_en
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign we_n[g] = !((state == ST_STRB) && be_q[g]);
   end

   assign drive_en = (state == ST_STRB) || (state == ST_HOLD);

endmodule

// File: rtl/sram_acc_fsm.sv
module sram_acc_fsm
   import sram_lane_ctrl_pkg::*;
#(
   parameter int RD_CYC = 2,
   parameter int WP_CYC = 1,
   parameter int WH_CYC = 1,
   parameter int CNT_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             tmr_zero,
   output acc_state_t       state,
   output logic             accept,
   output logic             done,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val
);

   localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
   localparam logic [CNT_W-1:0] WH_LD = CNT_W'(WH_CYC - 1);

   acc_state_t nxt;

   always_comb begin
      nxt      = state;
      accept   = 1'b0;
      done     = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state)
         ST_IDLE: if (req_valid) begin
            accept   = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = req_write ? WP_LD : RD_LD;
            nxt      = req_write ? ST_STRB : ST_READ;
         end
         ST_READ: if (tmr_zero) begin
            done = 1'b1;
            nxt  = ST_IDLE;
         end
         ST_STRB: if (tmr_zero) begin
            tmr_load = 1'b1;
            tmr_val  = WH_LD;
            nxt      = ST_HOLD;
         end
         ST_HOLD: if (tmr_zero) begin
            done = 1'b1;
            nxt  = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   // R8: a new access is only started from the idle state
   a_r8_accept_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (state == ST_READ || state == ST_STRB));

   // R6: every strobe phase is followed by a hold phase
   a_r6_hold_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STRB && tmr_zero) |=> (state == ST_HOLD));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_ctrl_pkg::*;
#(
   parameter int ADDR_W       = 17,
   parameter int DATA_W       = 32,
   parameter int LANE_W       = 8,
   parameter int CLK_NS       = 20,
   parameter int RD_ACC_NS    = 25,
   parameter int WR_PULSE_NS  = 20,
   parameter int WR_DSETUP_NS = 15,
   parameter int WR_CYCLE_NS  = 25
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   output logic                       req_ready,
   input  logic                       req_write,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [DATA_W-1:0]          req_wdata,
   input  logic [DATA_W/LANE_W-1:0]   req_be,
   output logic                       rsp_valid,
   output logic [DATA_W-1:0]          rsp_rdata,
   output logic [ADDR_W-1:0]          sram_addr,
   output logic                       sram_ce_n,
   output logic                       sram_oe_n,
   output logic [DATA_W/LANE_W-1:0]   sram_we_n,
   inout  wire  [DATA_W-1:0]          sram_dq
);

   localparam int LANES   = DATA_W / LANE_W;
   localparam int RD_CYC  = ceil_div(RD_ACC_NS, CLK_NS);
   localparam int WP_CYC  = max2(1, max2(ceil_div(WR_PULSE_NS, CLK_NS),
                                          ceil_div(WR_DSETUP_NS, CLK_NS)));
   localparam int WH_CYC  = max2(1, ceil_div(WR_CYCLE_NS, CLK_NS) - WP_CYC);
   localparam int CNT_MAX = max2(RD_CYC, max2(WP_CYC, WH_CYC));
   localparam int CNT_W   = max2(1, $clog2(CNT_MAX));

   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("DATA_W must be a whole number of lanes");
   end
   if (CLK_NS < 1 || RD_CYC < 1) begin : g_bad_time
      $error("clock period and read access time must be positive");
   end

   acc_state_t       state;
   logic             accept, done, tmr_load, tmr_zero, drive_en;
   logic [CNT_W-1:0] tmr_val;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, rdata_q;
   logic [LANES-1:0]  be_q;
   logic              rsp_q;

   sram_acc_fsm #(
      .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .WH_CYC(WH_CYC), .CNT_W(CNT_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .tmr_zero(tmr_zero), .state(state), .accept(accept), .done(done),
      .tmr_load(tmr_load), .tmr_val(tmr_val)
   );

   sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .zero(tmr_zero)
   );

   sram_lane_strobes #(.LANES(LANES)) u_strb (
      .state(state), .be_q(be_q), .we_n(sram_we_n), .drive_en(drive_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         be_q    <= '0;
         rdata_q <= '0;
         rsp_q   <= 1'b0;
      end else begin
         rsp_q <= done;
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_write ? req_be : '0;
         end
         if (done && state == ST_READ)
            rdata_q <= sram_dq;
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign rsp_valid = rsp_q;
   assign rsp_rdata = rdata_q;
   assign sram_addr = addr_q;
   assign sram_ce_n = (state == ST_IDLE);
   assign sram_oe_n = (state != ST_READ);
   assign sram_dq   = drive_en ? wdata_q : {DATA_W{1'bz}};

   // R2: standby keeps every other control inactive
   a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      sram_ce_n |-> (sram_oe_n && (&sram_we_n)));

   // R4: no output enable while any lane strobes
   a_r4_no_oe_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      !(&sram_we_n) |-> sram_oe_n);

   // R7: bus released in the cycle before output enable asserts
   a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_oe_n) |-> $past(!drive_en && sram_ce_n));

   // R10: address steady while the chip is selected
   a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

   // R3: the response follows the end of an access
   a_r3_rsp_after_access: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(!sram_ce_n) && sram_ce_n));

endmodule

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

   localparam int CLK_NS = 20;
   // independent cycle expectations from the nanosecond figures
   localparam int EXP_RD   = (25 + CLK_NS - 1) / CLK_NS;
   localparam int EXP_WP   = 1;
   localparam int EXP_WTOT = 2;

   typedef struct packed {
      logic        wr;
      logic [16:0] addr;
      logic [31:0] data;
      logic [3:0]  be;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 17'h00010, 32'h11223344, 4'hF, 32'h0},
      '{1'b0, 17'h00010, 32'h0,        4'h0, 32'h11223344},
      '{1'b1, 17'h00010, 32'hAABBCCDD, 4'h5, 32'h0},
      '{1'b0, 17'h00010, 32'h0,        4'h0, 32'h11BB33DD},
      '{1'b1, 17'h00020, 32'hFFFFFFFF, 4'h0, 32'h0},
      '{1'b0, 17'h00020, 32'h0,        4'h0, 32'h00000000},
      '{1'b1, 17'h1FF3C, 32'hCAFEF00D, 4'hA, 32'h0},
      '{1'b0, 17'h1FF3C, 32'h0,        4'h0, 32'hCA00F000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_be = '0;
   logic        req_ready, rsp_valid, sram_ce_n, sram_oe_n;
   logic [31:0] rsp_rdata;
   logic [16:0] sram_addr;
   logic [3:0]  sram_we_n;
   wire  [31:0] sram_dq;

   int nchk = 0, nerr = 0;
   logic [31:0] mem [256];

   always #10 clk = ~clk;

   sram_lane_ctrl i_sram_lane_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
      .sram_we_n(sram_we_n), .sram_dq(sram_dq)
   );

   // behavioural memory
   assign sram_dq = (!sram_ce_n && !sram_oe_n && (&sram_we_n)) ?
                    mem[sram_addr[7:0]] : 32'hzzzzzzzz;

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= '0;
      end else if (!sram_ce_n) begin
         for (int l = 0; l < 4; l++)
            if (!sram_we_n[l]) mem[sram_addr[7:0]][l*8 +: 8] <= sram_dq[l*8 +: 8];
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // R7 monitor: idle cycle between a write strobe and the next read
   bit pend_wr = 0, seen_idle = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (sram_we_n != 4'hF) begin
            pend_wr   = 1;
            seen_idle = 0;
         end else if (sram_ce_n) begin
            seen_idle = 1;
         end else if (!sram_oe_n && pend_wr) begin
            chk(seen_idle, "R7 idle gap before read", 32'(seen_idle), 32'd1);
            pend_wr = 0;
         end
      end
   end

   int          s_ce, s_oe, s_we, s_lat;
   logic [3:0]  s_pat;
   logic [31:0] s_rdata;
   bit          s_addr_ok, s_data_ok, s_rdy_ok;

   task automatic do_req(input logic wr, input logic [16:0] a,
                         input logic [31:0] d, input logic [3:0] be);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      s_ce = 0; s_oe = 0; s_we = 0; s_lat = 0; s_pat = 4'hF;
      s_addr_ok = 1; s_data_ok = 1; s_rdy_ok = 1;
      for (int k = 0; k < 40; k++) begin
         if (rsp_valid) begin
            s_rdata = rsp_rdata;
            break;
         end
         s_lat++;
         if (req_ready) s_rdy_ok = 0;
         if (!sram_ce_n) begin
            s_ce++;
            if (sram_addr != a) s_addr_ok = 0;
         end
         if (!sram_oe_n) s_oe++;
         if (sram_we_n != 4'hF) begin
            s_we++;
            s_pat = s_pat & sram_we_n;
            if (sram_dq !== d) s_data_ok = 0;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(sram_ce_n && sram_oe_n && sram_we_n == 4'hF, "R1 pins idle in reset",
          {28'd0, sram_ce_n, sram_oe_n, sram_we_n[1:0]}, 32'hF);
      chk(req_ready && !rsp_valid, "R1 handshake idle in reset",
          {30'd0, req_ready, rsp_valid}, 32'h2);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sram_ce_n && sram_oe_n && sram_we_n == 4'hF && req_ready,
          "R1 idle after reset", {28'd0, sram_ce_n, sram_oe_n, req_ready, 1'b1}, 32'hF);

      foreach (VECS[i]) begin
         do_req(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].be);
         chk(s_addr_ok, "R10 address held", 32'(s_addr_ok), 32'd1);
         chk(s_rdy_ok, "R8 ready low while busy", 32'(s_rdy_ok), 32'd1);
         if (VECS[i].wr) begin
            chk(s_ce == EXP_WTOT, "R6 write select cycles", s_ce, EXP_WTOT);
            chk(s_lat == EXP_WTOT, "R6 write response latency", s_lat, EXP_WTOT);
            chk(s_oe == 0, "R4 oe high in write", s_oe, 0);
            if (VECS[i].be == 4'h0) begin
               chk(s_we == 0, "R9 no strobe for empty mask", s_we, 0);
            end else begin
               chk(s_we == EXP_WP, "R4 strobe length", s_we, EXP_WP);
               chk(s_pat == ~VECS[i].be, "R4 lane strobes", {28'd0, s_pat},
                   {28'd0, ~VECS[i].be});
               chk(s_data_ok, "R5 data driven in strobe", 32'(s_data_ok), 32'd1);
            end
         end else begin
            chk(s_oe == EXP_RD && s_ce == EXP_RD, "R3 read enable cycles",
                s_oe, EXP_RD);
            chk(s_we == 0, "R3 no strobe in read", s_we, 0);
            chk(s_lat == EXP_RD, "R3 read response latency", s_lat, EXP_RD);
            chk(s_rdata == VECS[i].exp, "R5 R9 read-back data", s_rdata, VECS[i].exp);
         end
      end

      // R2 standby between requests
      @(negedge clk);
      chk(sram_ce_n && sram_oe_n && sram_we_n == 4'hF, "R2 standby quiet",
          {28'd0, sram_ce_n, sram_oe_n, sram_we_n[1:0]}, 32'hF);

      // R1 reset during a write strobe
      req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h5; req_wdata = '1; req_be = 4'hF;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(sram_we_n == 4'h0, "R4 strobe before reset", {28'd0, sram_we_n}, 32'h0);
      rst_n = 1'b0;
      #1;
      chk(sram_ce_n && sram_oe_n && sram_we_n == 4'hF && req_ready,
          "R1 reset aborts access", {28'd0, sram_ce_n, sram_oe_n, req_ready, 1'b1}, 32'hF);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!rsp_valid, "R1 no response after abort", 32'(rsp_valid), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule